// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block runs on the secondary side of a forward converter. It drives two gate-enable outputs, one for the control rectifier and one for the freewheeling rectifier. The only timing it gets is two shared trigger lines. A rising edge on the turn-on trigger switches on whichever rectifier is next in a fixed alternating order. A rising edge on the turn-off trigger switches off whichever rectifier is on. The block works out from these shared edges which rectifier each pulse belongs to.

A third input is a digitized flag from a predictive comparator. In discontinuous conduction this flag ends freewheeling conduction before the inductor current reverses, without waiting for the turn-off trigger. While the control rectifier is on, the flag has no effect. In continuous conduction the triggers alone set the timing.

Between the two gates the block enforces break-before-make. A turn-on that arrives too early is held as a pending request until a programmable dead time has passed. All inputs are assumed to be synchronous to `clk`.

Top module: `sr_gate_seq`

## Requirements
- R1: After reset both gate outputs are low and the sequence points at the control rectifier, so the first accepted turn-on enables `ctl_gate`.
- R2: Only a rising edge of a trigger acts. A trigger held high produces one action, and it acts again only after it has gone low and then high.
- R3: Accepted turn-ons alternate: control, freewheeling, control, and so on.
- R4: A rising edge on `off_trig` drives both gates low at the next clock edge.
- R5: A turn-on edge is ignored while either gate is on or while a turn-on request is already pending.
- R6: A gate rises only after both gates have been low for at least `dead_cfg`+1 consecutive cycles. A request that arrives earlier stays pending until that holds, and a turn-off edge cancels the pending request without advancing the sequence.
- R7: `ctl_gate` and `fw_gate` are never high in the same cycle.
- R8: When turn-on and turn-off edges arrive in the same cycle, the turn-off wins and the turn-on is discarded. No request stays pending and the sequence does not advance.
- R9: `cutoff_flag` high while `ctl_gate` is low forces `fw_gate` low at the next clock edge, independently of `off_trig`. While `ctl_gate` is high the flag has no effect.
- R10: Once the cutoff has acted while the freewheeling rectifier is next or on, the freewheeling gate stays off and the next accepted turn-on enables the control rectifier.
- R11: A turn-on edge that meets the dead-time condition raises its gate at the same clock edge that samples the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| on_trig | input | 1 | Shared turn-on trigger; rising edge acts |
| off_trig | input | 1 | Shared turn-off trigger; rising edge acts |
| cutoff_flag | input | 1 | Predictive cutoff from the comparator; high ends freewheeling |
| dead_cfg | input | DEAD_W | Minimum dead time in clock cycles, less one |
| ctl_gate | output | 1 | Gate enable for the control rectifier |
| fw_gate | output | 1 | Gate enable for the freewheeling rectifier |

## Verification
The main function is tried with several input patterns:
- Plain alternating on/off pulse trains with zero dead time, which show whether the sequence position is tracked.
- Redundant turn-on pulses while a gate is on, which separate an ignored trigger from one that advances the order.
- An early turn-on with a dead time of five, which shows whether the request is held and exactly when it is granted.
- The same early turn-on followed by a turn-off, which shows whether the pending request is cancelled or leaks through.
- Coincident turn-on and turn-off edges, a cutoff both with and without the control gate on, and a trigger held high, which separate edge action from level action and show that the cutoff takes priority.

// File: rtl/sr_seq_pkg.sv
// Package: shared selector type for the rectifier sequencer.
// Assumes: nothing beyond the two rectifiers it names.
package sr_seq_pkg;

    // Which rectifier the next accepted turn-on targets.
    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_FW   = 1'b1
    } rect_sel_e;

endpackage

// File: rtl/sr_edge_det.sv
// Module: sr_edge_det
// Detects rising edges on N synchronous level inputs, one cycle wide.
// Assumes: inputs are already synchronous to clk; history clears to 0 on reset.
module sr_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Register the previous level of one input.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= lvl[i];
        end
        assign rise[i] = lvl[i] & ~prev_q[i];
    end

endmodule

// File: rtl/sr_dead_timer.sv
// Module: sr_dead_timer
// Counts consecutive cycles with both gates low and reports when the
// programmed dead time has been met.
// Assumes: counter saturates; reset starts saturated so the first turn-on is free.
module sr_dead_timer #(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_on,
    input  logic [DEAD_W-1:0] dead_cfg,
    output logic              dead_ok
);

    localparam logic [DEAD_W-1:0] CNT_MAX = {DEAD_W{1'b1}};

    logic [DEAD_W-1:0] cnt_q;

    // Track how long both gates have been off.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= CNT_MAX;
        else if (any_on)          cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign dead_ok = ~any_on & (cnt_q >= dead_cfg);

endmodule

// File: rtl/sr_gate_fsm.sv
// Module: sr_gate_fsm
// Holds both gate states, the sequence position and a pending turn-on request.
// Applies turn-off before turn-on, and the predictive cutoff last.
// Assumes: trigger inputs are single-cycle edge strobes; dead_ok already
// includes the both-gates-off condition.
module sr_gate_fsm
    import sr_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic on_rise,
    input  logic off_rise,
    input  logic cutoff,
    input  logic dead_ok,
    output logic ctl_gate,
    output logic fw_gate
);

    logic      ctl_q, fw_q, pend_q;
    rect_sel_e sel_q;
    logic      ctl_n, fw_n, pend_n;
    rect_sel_e sel_n;
    logic      cut_act, fw_block, start;

    // Next-state decode of gates, request and sequence position.
    always_comb begin
        ctl_n    = ctl_q;
        fw_n     = fw_q;
        pend_n   = pend_q;
        sel_n    = sel_q;
        cut_act  = cutoff & ~ctl_q;
        fw_block = cut_act & (sel_q == SEL_FW);
        start    = ~off_rise & (pend_q | (on_rise & ~ctl_q & ~fw_q));
        if (off_rise) begin
            ctl_n  = 1'b0;
            fw_n   = 1'b0;
            pend_n = 1'b0;
        end else if (start && !fw_block) begin
            if (dead_ok) begin
                if (sel_q == SEL_CTRL) ctl_n = 1'b1;
                else                   fw_n  = 1'b1;
                sel_n  = (sel_q == SEL_CTRL) ? SEL_FW : SEL_CTRL;
                pend_n = 1'b0;
            end else begin
                pend_n = 1'b1;
            end
        end
        if (cut_act) fw_n = 1'b0;
        if (fw_block) begin
            sel_n  = SEL_CTRL;
            pend_n = 1'b0;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= 1'b0;
            fw_q   <= 1'b0;
            pend_q <= 1'b0;
            sel_q  <= SEL_CTRL;
        end else begin
            ctl_q  <= ctl_n;
            fw_q   <= fw_n;
            pend_q <= pend_n;
            sel_q  <= sel_n;
        end
    end

    assign ctl_gate = ctl_q;
    assign fw_gate  = fw_q;

endmodule

// File: rtl/sr_gate_seq.sv
// Module: sr_gate_seq (top)
// Rebuilds the two rectifier gate enables from shared turn-on and turn-off
// trigger edges, with a dead-time interlock and a predictive cutoff.
// Assumes: all inputs synchronous to clk; dead_cfg quasi-static.
module sr_gate_seq #(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              on_trig,
    input  logic              off_trig,
    input  logic              cutoff_flag,
    input  logic [DEAD_W-1:0] dead_cfg,
    output logic              ctl_gate,
    output logic              fw_gate
);

    localparam int NTRIG = 2;
    localparam int IDX_ON  = 0;
    localparam int IDX_OFF = 1;

    logic [NTRIG-1:0] trig_rise;
    logic             dead_ok;

    sr_edge_det #(.N(NTRIG)) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   ({off_trig, on_trig}),
        .rise  (trig_rise)
    );

    sr_dead_timer #(.DEAD_W(DEAD_W)) dead_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_on   (ctl_gate | fw_gate),
        .dead_cfg (dead_cfg),
        .dead_ok  (dead_ok)
    );

    sr_gate_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .on_rise  (trig_rise[IDX_ON]),
        .off_rise (trig_rise[IDX_OFF]),
        .cutoff   (cutoff_flag),
        .dead_ok  (dead_ok),
        .ctl_gate (ctl_gate),
        .fw_gate  (fw_gate)
    );

endmodule

// File: rtl/sr_gate_seq_chk.sv
// Module: sr_gate_seq_chk
// Property checker for sr_gate_seq, attached by bind.
// Assumes: the same reset and clock as the top module.
module sr_gate_seq_chk #(
    parameter int DEAD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              on_trig,
    input logic              off_trig,
    input logic              cutoff_flag,
    input logic [DEAD_W-1:0] dead_cfg,
    input logic              ctl_gate,
    input logic              fw_gate
);

    localparam logic [DEAD_W:0] RUN_MAX = {(DEAD_W+1){1'b1}};

    logic [DEAD_W:0] run_q;

    // Independent count of cycles with both gates low.
    always_ff @(posedge clk) begin
        if (!rst_n)                  run_q <= RUN_MAX;
        else if (ctl_gate || fw_gate) run_q <= '0;
        else if (run_q != RUN_MAX)   run_q <= run_q + 1'b1;
    end

    AST_GATE_MUTEX: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_gate && fw_gate)); // R7

    AST_OFF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(off_trig) |=> (!ctl_gate && !fw_gate)); // R4

    AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(on_trig) && $rose(off_trig)) |=> (!ctl_gate && !fw_gate)); // R8

    AST_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cutoff_flag && !ctl_gate) |=> !fw_gate); // R9

    AST_DEAD_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl_gate) || $rose(fw_gate)) |-> (run_q > {1'b0, $past(dead_cfg)})); // R6

endmodule

bind sr_gate_seq sr_gate_seq_chk #(.DEAD_W(DEAD_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .on_trig     (on_trig),
    .off_trig    (off_trig),
    .cutoff_flag (cutoff_flag),
    .dead_cfg    (dead_cfg),
    .ctl_gate    (ctl_gate),
    .fw_gate     (fw_gate)
);

// File: tb/sr_gate_seq_tb_top.sv
module sr_gate_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int WATCHDOG = 5000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          on_trig = 1'b0;
    logic          off_trig = 1'b0;
    logic          cutoff_flag = 1'b0;
    logic [DW-1:0] dead_cfg = '0;
    logic          ctl_gate, fw_gate;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_gate_seq #(.DEAD_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .on_trig(on_trig), .off_trig(off_trig),
        .cutoff_flag(cutoff_flag), .dead_cfg(dead_cfg),
        .ctl_gate(ctl_gate), .fw_gate(fw_gate)
    );

    // Behavioural reference: integer state, updated on each rising clock.
    int m_ctl, m_fw, m_pend, m_next, m_cnt, m_pon, m_poff;
    always @(posedge clk) begin
        int ron, roff, cutv, blk, ok, st, nc;
        if (!rst_n) begin
            m_ctl = 0; m_fw = 0; m_pend = 0; m_next = 0; m_cnt = 255;
            m_pon = 0; m_poff = 0;
        end else begin
            ron  = (on_trig && !m_pon) ? 1 : 0;
            roff = (off_trig && !m_poff) ? 1 : 0;
            m_pon = on_trig; m_poff = off_trig;
            cutv = (cutoff_flag && m_ctl == 0) ? 1 : 0;
            blk  = (cutv == 1 && m_next == 1) ? 1 : 0;
            ok   = (m_ctl == 0 && m_fw == 0 && m_cnt >= int'(dead_cfg)) ? 1 : 0;
            nc   = (m_ctl == 1 || m_fw == 1) ? 0 : ((m_cnt < 255) ? m_cnt + 1 : 255);
            st   = (m_pend == 1 || (ron == 1 && m_ctl == 0 && m_fw == 0)) ? 1 : 0;
            if (roff == 1) begin
                m_ctl = 0; m_fw = 0; m_pend = 0;
            end else if (st == 1 && blk == 0) begin
                if (ok == 1) begin
                    if (m_next == 0) m_ctl = 1; else m_fw = 1;
                    m_next = 1 - m_next;
                    m_pend = 0;
                end else m_pend = 1;
            end
            if (cutv == 1) m_fw = 0;
            if (blk == 1) begin m_next = 0; m_pend = 0; end
            m_cnt = nc;
        end
    end

    // Compare against the reference on every falling clock.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (int'(ctl_gate) != m_ctl || int'(fw_gate) != m_fw || (ctl_gate && fw_gate)) begin
                errors++;
                $display("FAIL R7/model: ctl=%0d fw=%0d expected ctl=%0d fw=%0d",
                         ctl_gate, fw_gate, m_ctl, m_fw);
            end
        end
    end

    task automatic chk(input logic ec, input logic ef, input string tag);
        checks++;
        if (ctl_gate !== ec || fw_gate !== ef) begin
            errors++;
            $display("FAIL %s: ctl=%0b fw=%0b expected ctl=%0b fw=%0b",
                     tag, ctl_gate, fw_gate, ec, ef);
        end
    endtask

    task automatic pulse_on();
        @(negedge clk) on_trig = 1'b1;
        @(negedge clk) on_trig = 1'b0;
    endtask

    task automatic pulse_off();
        @(negedge clk) off_trig = 1'b1;
        @(negedge clk) off_trig = 1'b0;
    endtask

    // Watchdog: an overlong run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(1'b0, 1'b0, "R1 reset state");

        pulse_on();  chk(1'b1, 1'b0, "R1 R11 first turn-on is control");
        pulse_on();  chk(1'b1, 1'b0, "R5 turn-on ignored while gate on");
        pulse_off(); chk(1'b0, 1'b0, "R4 turn-off clears control");
        pulse_on();  chk(1'b0, 1'b1, "R3 freewheel follows control");
        pulse_off(); chk(1'b0, 1'b0, "R4 turn-off clears freewheel");
        pulse_on();  chk(1'b1, 1'b0, "R3 control follows freewheel");

        // R6: early request held until dead time of 5 met.
        dead_cfg = 8'd5;
        pulse_off();
        on_trig = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            on_trig = 1'b0;
            n++;
        end while (!fw_gate && n < 20);
        checks++;
        if (n != 6) begin
            errors++;
            $display("FAIL R6 grant delay: actual=%0d expected=%0d", n, 6);
        end

        // R6: turn-off cancels a pending request.
        pulse_off();
        on_trig = 1'b1;
        @(negedge clk) on_trig = 1'b0;
        pulse_off();
        repeat (10) @(negedge clk);
        chk(1'b0, 1'b0, "R6 pending cancelled by turn-off");
        dead_cfg = '0;
        pulse_on();  chk(1'b1, 1'b0, "R6 sequence kept after cancel");

        // R8: coincident edges.
        pulse_off();
        @(negedge clk) begin on_trig = 1'b1; off_trig = 1'b1; end
        @(negedge clk) begin on_trig = 1'b0; off_trig = 1'b0; end
        repeat (3) @(negedge clk);
        chk(1'b0, 1'b0, "R8 turn-off wins");
        pulse_on();  chk(1'b0, 1'b1, "R8 sequence not advanced");

        // R9 / R10: cutoff during freewheeling.
        @(negedge clk) cutoff_flag = 1'b1;
        @(negedge clk) chk(1'b0, 1'b0, "R9 cutoff ends freewheel");
        cutoff_flag = 1'b0;
        pulse_on();  chk(1'b1, 1'b0, "R10 control after cutoff");

        cutoff_flag = 1'b1;
        repeat (3) @(negedge clk);
        chk(1'b1, 1'b0, "R9 cutoff ignored while control on");
        pulse_off();
        pulse_on();  chk(1'b1, 1'b0, "R10 freewheel skipped under cutoff");
        cutoff_flag = 1'b0;

        // R2: level held high acts once.
        pulse_off();
        @(negedge clk) on_trig = 1'b1;
        repeat (2) @(negedge clk);
        chk(1'b0, 1'b1, "R2 held trigger acts once");
        @(negedge clk) off_trig = 1'b1;
        @(negedge clk) off_trig = 1'b0;
        repeat (3) @(negedge clk);
        chk(1'b0, 1'b0, "R2 held trigger does not retrigger");
        on_trig = 1'b0;
        repeat (2) @(negedge clk);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule